// File: doc/BRIEF.md
# Segmented Pseudo-Random Stimulus Generator

This block produces a stream of pseudo-random test vectors of a parameterised width for driving a design under test. The vector is built from several independent Fibonacci shift-register generators laid side by side. Each one is at most 31 bits wide and uses a maximal-length feedback polynomial. A single `start` pulse launches a scenario of a fixed number of vectors, one per clock. `valid` marks each vector, and `done` marks the last one.

The vector width is split into segments by a fixed rule that never leaves a one-bit generator. Each segment starts from its own seed, which is derived from a base value and a step. Narrow segments run through their whole period several times within a scenario. Wide segments are simply cut off when the scenario ends. Every `start` reloads all seeds, so repeated scenarios produce identical streams.

Top module: `stim_vector_gen`

## Requirements
- R1: The vector of width W is split into W/31 (integer division) segments of 31 bits, plus one segment holding the remaining W mod 31 bits when that remainder is nonzero. Segment 0 occupies the least significant bits, and each later segment sits directly above the one before it.
- R2: When W mod 31 equals 1 and W is at least 32, the highest full segment becomes 30 bits wide and the last segment becomes 2 bits wide. For example, W=32 gives segment 0 in bits [29:0] and segment 1 in bits [31:30].
- R3: Each segment of width w shifts left by one bit on every vector. Bit 0 receives the XOR of the state bits selected by the tap mask. The masks, written as bit indices, are: w=2 {1,0}; w=9 {8,4}; w=30 {29,5,3,0}; w=31 {30,27}. Every width from 2 to 31 has a maximal-length mask.
- R4: The seed of segment i is (SEED_BASE + i*SEED_STEP) mod 2^32, masked to the segment width. A result of zero is replaced by all ones, so no segment state is ever zero.
- R5: A `start` sampled high at a clock edge makes the concatenated seeds appear on `vec` with `valid` high in the following cycle.
- R6: Exactly SCEN_LEN (1000) vectors follow a start. `done` is high only during the cycle that presents the last of them. From the next cycle on, `valid` stays low until a new start.
- R7: A segment of width 9 or less reloads its seed after 2^w-1 steps. Its field therefore repeats every 2^w-1 vectors, with the seed reappearing at vector index 2^w-1. Wider segments never reload within a scenario.
- R8: Every scenario begins from the same seeds, so two complete scenarios produce bit-identical vector streams.
- R9: A start that arrives while a scenario is running abandons that scenario. The next cycle presents vector 0 of a fresh scenario.
- R10: After reset, and whenever `valid` is low, `vec` is all zeros and `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches (or relaunches) a scenario |
| vec | output | W | Stimulus vector, zero when not valid |
| valid | output | 1 | A vector is being presented |
| done | output | 1 | The final vector of the scenario is being presented |

## Verification
Several rules are checked on every cycle. The vector is zero and `done` is low while idle. The seed vector follows every start. `done` coincides with the last vector of the window, which the checker counts itself. `valid` falls only right after `done`, and a valid vector is never zero. The actual bit sequence, the segment partition, the short-period repetition, the relaunch mid-scenario and the bit-identical repeat show up only in the bench's scenarios. The bench runs two configurations, W=32 and W=40, and compares every vector against an arithmetic model.

// File: rtl/stim_pkg.sv
// Package: partition rule, tap masks and seed derivation shared by the
// stimulus generator and its checker. Assumes vector width >= 2.
package stim_pkg;

    localparam int SEG_MAX = 31;

    // Number of generator segments used for a vector of width w.
    function automatic int seg_count(input int w);
        return w / SEG_MAX + (((w % SEG_MAX) != 0) ? 1 : 0);
    endfunction

    // Width of segment i; a 1-bit tail borrows one bit from the segment below.
    function automatic int seg_width(input int w, input int i);
        int nfull;
        int rem;
        nfull = w / SEG_MAX;
        rem   = w % SEG_MAX;
        if (rem == 1 && nfull >= 1) begin
            if (i < nfull - 1) return SEG_MAX;
            if (i == nfull - 1) return SEG_MAX - 1;
            return 2;
        end
        if (i < nfull) return SEG_MAX;
        return rem;
    endfunction

    // Lowest vector bit of segment i.
    function automatic int seg_lsb(input int w, input int i);
        int acc;
        acc = 0;
        for (int k = 0; k < i; k++) acc += seg_width(w, k);
        return acc;
    endfunction

    // Maximal-length feedback taps, one bit per tapped state position.
    function automatic logic [30:0] tap_mask(input int w);
        case (w)
            2:  return 31'h0000_0003;
            3:  return 31'h0000_0006;
            4:  return 31'h0000_000C;
            5:  return 31'h0000_0014;
            6:  return 31'h0000_0030;
            7:  return 31'h0000_0060;
            8:  return 31'h0000_00B8;
            9:  return 31'h0000_0110;
            10: return 31'h0000_0240;
            11: return 31'h0000_0500;
            12: return 31'h0000_0829;
            13: return 31'h0000_100D;
            14: return 31'h0000_2015;
            15: return 31'h0000_6000;
            16: return 31'h0000_D008;
            17: return 31'h0001_2000;
            18: return 31'h0002_0400;
            19: return 31'h0004_0023;
            20: return 31'h0009_0000;
            21: return 31'h0014_0000;
            22: return 31'h0030_0000;
            23: return 31'h0042_0000;
            24: return 31'h00E1_0000;
            25: return 31'h0120_0000;
            26: return 31'h0200_0023;
            27: return 31'h0400_0013;
            28: return 31'h0900_0000;
            29: return 31'h1400_0000;
            30: return 31'h2000_0029;
            default: return 31'h4800_0000;
        endcase
    endfunction

    // Seed of segment i: base plus i steps, masked, zero forced to all ones.
    function automatic logic [30:0] seg_seed(input logic [31:0] base,
                                             input logic [31:0] step,
                                             input int i, input int w);
        logic [31:0] raw;
        logic [31:0] msk;
        raw = base + step * 32'(i);
        msk = (32'h1 << w) - 32'h1;
        raw = raw & msk;
        if (raw == 32'h0) raw = msk;
        return raw[30:0];
    endfunction

endpackage

// File: rtl/stim_seq_ctrl.sv
// Scenario sequencer: counts SCEN_LEN vectors after each start, flags the
// last one and tells the segments when to load and when to step.
// Assumes SCEN_LEN >= 2. A start always wins over an ongoing scenario.
module stim_seq_ctrl #(
    parameter int SCEN_LEN = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic last,
    output logic load,
    output logic step
);
    localparam int CW = $clog2(SCEN_LEN);
    localparam logic [CW-1:0] LAST_IDX = CW'(SCEN_LEN - 1);

    logic [CW-1:0] idx;

    // Scenario state: active flag and index of the vector being presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (active) begin
            if (idx == LAST_IDX) begin
                active <= 1'b0;
                idx    <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // Decode of the final vector and segment control strobes.
    always_comb begin
        last = active && (idx == LAST_IDX);
        load = start;
        step = active;
    end

endmodule

// File: rtl/stim_lfsr_seg.sv
// One Fibonacci shift-register segment, left shifting with XOR feedback into
// bit 0. Segments of at most REPEAT_MAX bits carry a step counter and reload
// their seed explicitly after a full period. Assumes 2 <= WIDTH <= 31 and a
// nonzero SEED.
module stim_lfsr_seg #(
    parameter int          WIDTH      = 8,
    parameter logic [30:0] SEED       = 31'h1,
    parameter int          REPEAT_MAX = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    output logic [WIDTH-1:0] state
);
    import stim_pkg::*;

    localparam logic [30:0]      TAPS_FULL = tap_mask(WIDTH);
    localparam logic [WIDTH-1:0] TAPS      = TAPS_FULL[WIDTH-1:0];
    localparam logic [WIDTH-1:0] SEED_W    = SEED[WIDTH-1:0];

    logic [WIDTH-1:0] nxt;

    // Next state of the shift register.
    always_comb nxt = {state[WIDTH-2:0], ^(state & TAPS)};

    generate
        if (WIDTH <= REPEAT_MAX) begin : g_wrap
            localparam logic [WIDTH-1:0] PERIOD_END = {WIDTH{1'b1}} - 1'b1;
            logic [WIDTH-1:0] nstep;

            // Short segment: step with explicit seed reload at end of period.
            always_ff @(posedge clk) begin
                if (!rst_n || load) begin
                    state <= SEED_W;
                    nstep <= '0;
                end else if (step) begin
                    if (nstep == PERIOD_END) begin
                        state <= SEED_W;
                        nstep <= '0;
                    end else begin
                        state <= nxt;
                        nstep <= nstep + 1'b1;
                    end
                end
            end
        end else begin : g_free
            // Long segment: free-running, truncated by the sequencer.
            always_ff @(posedge clk) begin
                if (!rst_n || load) state <= SEED_W;
                else if (step)      state <= nxt;
            end
        end
    endgenerate

endmodule

// File: rtl/stim_vector_gen.sv
// Segmented stimulus generator top: partitions W into generator segments,
// gives each a derived seed and presents their concatenation for SCEN_LEN
// cycles after every start. Assumes W >= 2.
module stim_vector_gen #(
    parameter int          W          = 32,
    parameter int          SCEN_LEN   = 1000,
    parameter int          REPEAT_MAX = 9,
    parameter logic [31:0] SEED_BASE  = 32'h0000_0001,
    parameter logic [31:0] SEED_STEP  = 32'h9E37_79B9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    output logic [W-1:0] vec,
    output logic         valid,
    output logic         done
);
    import stim_pkg::*;

    localparam int NSEG = seg_count(W);

    logic         active;
    logic         last;
    logic         load;
    logic         step;
    logic [W-1:0] raw_vec;

    stim_seq_ctrl #(.SCEN_LEN(SCEN_LEN)) i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .active (active),
        .last   (last),
        .load   (load),
        .step   (step)
    );

    generate
        for (genvar i = 0; i < NSEG; i++) begin : g_seg
            localparam int          SW  = seg_width(W, i);
            localparam int          LSB = seg_lsb(W, i);
            localparam logic [30:0] SD  = seg_seed(SEED_BASE, SEED_STEP, i, SW);
            logic [SW-1:0] st;

            stim_lfsr_seg #(
                .WIDTH      (SW),
                .SEED       (SD),
                .REPEAT_MAX (REPEAT_MAX)
            ) i_seg (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (load),
                .step  (step),
                .state (st)
            );

            // Place this segment in its slice of the vector.
            assign raw_vec[LSB +: SW] = st;
        end
    endgenerate

    // Output gating: nothing but zeros leaves the block while idle.
    always_comb begin
        valid = active;
        done  = last;
        vec   = active ? raw_vec : '0;
    end

endmodule

// File: rtl/stim_vector_gen_chk.sv
// Checker for stim_vector_gen: keeps its own count of valid vectors since
// the last start and relates it to done/valid; bound into every instance.
module stim_vector_gen_chk #(
    parameter int          W          = 32,
    parameter int          SCEN_LEN   = 1000,
    parameter logic [31:0] SEED_BASE  = 32'h0000_0001,
    parameter logic [31:0] SEED_STEP  = 32'h9E37_79B9
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] vec,
    input logic         valid,
    input logic         done
);
    import stim_pkg::*;

    localparam int NSEG = seg_count(W);
    localparam int NW   = $clog2(SCEN_LEN + 1);

    function automatic logic [W-1:0] seed_vector();
        logic [W-1:0] v;
        logic [30:0]  s;
        int           sw;
        int           lo;
        v = '0;
        for (int i = 0; i < NSEG; i++) begin
            sw = seg_width(W, i);
            lo = seg_lsb(W, i);
            s  = seg_seed(SEED_BASE, SEED_STEP, i, sw);
            for (int b = 0; b < sw; b++) v[lo + b] = s[b];
        end
        return v;
    endfunction

    localparam logic [W-1:0] SEED_VEC = seed_vector();

    logic [NW-1:0] seen;

    // Count of vectors already presented in the current scenario.
    always_ff @(posedge clk) begin
        if (!rst_n || start) seen <= '0;
        else if (valid)      seen <= seen + 1'b1;
    end

    p_first_is_seed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (valid && vec == SEED_VEC));

    p_done_on_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (valid && seen == NW'(SCEN_LEN - 1)));

    p_last_has_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && seen == NW'(SCEN_LEN - 1)) |-> done);

    p_drop_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid) |-> $past(done));

    p_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (vec != '0));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (vec == '0 && !done));

endmodule

bind stim_vector_gen stim_vector_gen_chk #(
    .W         (W),
    .SCEN_LEN  (SCEN_LEN),
    .SEED_BASE (SEED_BASE),
    .SEED_STEP (SEED_STEP)
) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .vec   (vec),
    .valid (valid),
    .done  (done)
);

// File: tb/test_stim_vector_gen.sv
`timescale 1ns/1ps
module test_stim_vector_gen;

    localparam int          LEN   = 1000;
    localparam logic [31:0] STEP  = 32'h9E37_79B9;
    localparam logic [31:0] BASEA = 32'h0000_0000;
    localparam logic [31:0] BASEB = 32'h5A5A_1234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] vec_a;
    logic [39:0] vec_b;
    logic        valid_a, done_a, valid_b, done_b;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [31:0] a0, a1, b0, b1;
    logic [39:0] first_b [8];

    always #10 clk = ~clk;

    // Instance A: W=32 exercises the 30+2 split and a zero base seed.
    stim_vector_gen #(.W(32), .SCEN_LEN(LEN), .SEED_BASE(BASEA), .SEED_STEP(STEP))
        i_stim_vector_gen (.clk(clk), .rst_n(rst_n), .start(start),
                           .vec(vec_a), .valid(valid_a), .done(done_a));

    // Instance B: W=40 gives a 31-bit segment and a repeating 9-bit segment.
    stim_vector_gen #(.W(40), .SCEN_LEN(LEN), .SEED_BASE(BASEB), .SEED_STEP(STEP))
        i_stim_vector_gen_b (.clk(clk), .rst_n(rst_n), .start(start),
                             .vec(vec_b), .valid(valid_b), .done(done_b));

    function automatic logic [31:0] mk_seed(logic [31:0] base, int i, int w);
        logic [31:0] m, s;
        m = (32'h1 << w) - 32'h1;
        s = (base + STEP * 32'(i)) & m;
        return (s == 0) ? m : s;
    endfunction

    function automatic logic [31:0] taps(int w);
        case (w)
            2:  return 32'h3;
            9:  return 32'h110;
            30: return 32'h2000_0029;
            default: return 32'h4800_0000;
        endcase
    endfunction

    function automatic logic [31:0] adv(logic [31:0] s, int w);
        logic [31:0] m;
        m = (32'h1 << w) - 32'h1;
        return ((s << 1) | {31'b0, ^(s & taps(w))}) & m;
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_init();
        a0 = mk_seed(BASEA, 0, 30);
        a1 = mk_seed(BASEA, 1, 2);
        b0 = mk_seed(BASEB, 0, 31);
        b1 = mk_seed(BASEB, 1, 9);
    endtask

    // Runs a scenario for upto vectors, comparing each against the model.
    task automatic scenario(int upto, int mode);
        logic [31:0] ea;
        logic [39:0] eb;
        model_init();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < upto; k++) begin
            ea = {a1[1:0], a0[29:0]};
            eb = {b1[8:0], b0[30:0]};
            // R1 R2 R3 R4 R5 R6: full vector, valid and done per cycle
            chk(valid_a && (done_a == (k == LEN-1)) && vec_a == ea,
                "R1/R2/R3 vec A", {31'b0, valid_a, vec_a}, {31'b0, 1'b1, ea});
            chk(valid_b && (done_b == (k == LEN-1)) && vec_b == eb,
                "R1/R3/R4 vec B", {23'b0, valid_b, vec_b}, {23'b0, 1'b1, eb});
            if (k == 0) begin
                chk(vec_a[29:0] == 30'h3FFF_FFFF, "R4 zero seed to ones",
                    64'(vec_a[29:0]), 64'h3FFF_FFFF);
                chk(vec_b == {mk_seed(BASEB, 1, 9)[8:0], mk_seed(BASEB, 0, 31)[30:0]},
                    "R5 seed first", 64'(vec_b),
                    64'({mk_seed(BASEB, 1, 9)[8:0], mk_seed(BASEB, 0, 31)[30:0]}));
            end
            if (k == 3)
                chk(vec_a[31:30] == mk_seed(BASEA, 1, 2)[1:0], "R7 2-bit period",
                    64'(vec_a[31:30]), 64'(mk_seed(BASEA, 1, 2)[1:0]));
            if (k == 511)
                chk(vec_b[39:31] == mk_seed(BASEB, 1, 9)[8:0], "R7 9-bit period",
                    64'(vec_b[39:31]), 64'(mk_seed(BASEB, 1, 9)[8:0]));
            if (k < 8) begin
                if (mode == 0) first_b[k] = vec_b;
                if (mode == 2)
                    chk(vec_b == first_b[k], "R8 identical rerun",
                        64'(vec_b), 64'(first_b[k]));
            end
            a0 = adv(a0, 30); a1 = adv(a1, 2);
            b0 = adv(b0, 31); b1 = adv(b1, 9);
            if (k != upto - 1) @(negedge clk);
        end
        if (upto == LEN) begin
            @(negedge clk);
            chk(!valid_a && !valid_b && !done_a && !done_b && vec_a == 0 && vec_b == 0,
                "R6/R10 idle after last", {62'b0, valid_a, valid_b}, 64'h0);
        end
    endtask

    initial begin
        #(20.0 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(!valid_a && !done_a && vec_a == 0 && !valid_b && !done_b && vec_b == 0,
            "R10 reset state", {62'b0, valid_a, valid_b}, 64'h0);
        scenario(LEN, 0);
        repeat (5) @(negedge clk);
        chk(!valid_b && !done_b && vec_b == 0, "R6 stays idle", 64'(vec_b), 64'h0);
        // R9: relaunch after 500 vectors; scenario() restarts at that edge
        scenario(500, 1);
        @(negedge clk);
        scenario(LEN, 2);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule